// File: doc/BRIEF.md
# Disk Sector Result Status Generator

This block assembles the two status bytes that a floppy disk controller returns once a sector read finishes. The read datapath sends it single-cycle event strobes: an address mark was found (normal or deleted), the data-field CRC check finished, the data mark timed out, and the sector ID was decoded along with its track number. The block compares these events with the command type and with the controller's own track register. From that it sets sticky error flags in a result byte. A command-start strobe clears the flags.

A second byte reports the drive status. It is built from the write-protect, track-0, head-select and drive-select pins, each passed through a two-flop synchronizer. A configuration input can force the reported write-protect bit high. All pins are plain control and status signals. Nothing here is a data stream, so there is no valid/ready handshake and no back-pressure. Both bytes can be read at any time.

Top module: `sector_status_gen`

## Requirements
- R1: While reset is asserted and after it is released, `result_byte` reads 0x00. With all drive pins and `force_wp` low, `drive_byte` reads 0x28.
- R2: On `cmd_start`, the block captures `cmd_deleted` (1 means a deleted-data read). A later `mark_found` strobe sets result bit 6 when `mark_deleted` differs from the captured command type. When they match, bit 6 is unchanged.
- R3: A `crc_done` strobe with `crc_bad`=1 sets result bit 5. With `crc_bad`=0 it has no effect.
- R4: An `id_valid` strobe sets result bit 4 when `id_track` differs from `cur_track`.
- R5: Result bit 1 is set by an `id_valid` strobe only when `id_track` differs from `cur_track` and `id_track` is all ones (0xFF). If both are 0xFF, neither bit 4 nor bit 1 is set.
- R6: A `mark_timeout` strobe sets result bit 0.
- R7: Each flag appears on `result_byte` after the clock edge that samples its strobe. It then holds until a `cmd_start`. A `cmd_start` makes the byte read 0x00 after its edge. Any event strobe in the same cycle as `cmd_start` is ignored. Result bits 7, 3 and 2 always read 0.
- R8: The `drive_byte` layout is:
  - bit 7 = 0
  - bit 6 = write protect
  - bit 5 = 1
  - bit 4 = track 0
  - bit 3 = 1
  - bit 2 = head select
  - bits 1:0 = drive select
- R9: A change on a drive pin reaches `drive_byte` on the second rising edge after it is applied, and not on the first.
- R10: `force_wp`=1 sets `drive_byte` bit 6 in the same cycle, without synchronizer delay and whatever the write-protect pin is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command-start strobe; clears flags |
| cmd_deleted | input | 1 | Command type at cmd_start: 1 = deleted-data read |
| mark_found | input | 1 | Data address mark detected strobe |
| mark_deleted | input | 1 | Found mark is a deleted mark |
| crc_done | input | 1 | Data-field CRC check finished strobe |
| crc_bad | input | 1 | CRC check failed |
| mark_timeout | input | 1 | No data mark found strobe |
| id_valid | input | 1 | Sector ID decoded strobe |
| id_track | input | TRACK_W | Track number from the sector ID |
| cur_track | input | TRACK_W | Controller's internal track register |
| pin_wp | input | 1 | Write-protect pin (asynchronous) |
| pin_trk0 | input | 1 | Track-0 pin (asynchronous) |
| pin_head | input | 1 | Head-select pin (asynchronous) |
| pin_dsel | input | 2 | Drive-select pins (asynchronous) |
| force_wp | input | 1 | Configuration: force write protect |
| result_byte | output | 8 | Sector result status byte |
| drive_byte | output | 8 | Drive status byte |

## Verification
The assertions assume that event strobes last exactly one cycle. They also assume that `mark_deleted`, `crc_bad` and `id_track`/`cur_track` are valid in the cycle their strobe is high. The sticky-flag checks assume only `cmd_start` or reset ever clears a flag. The stimulus changes every input at the falling edge and lowers each strobe after one rising edge. It raises an event together with `cmd_start` only in the scenario that tests the priority of `cmd_start`.

// File: rtl/sector_status_pkg.sv
package sector_status_pkg;

  localparam int DSEL_W = 2;
  localparam int PIN_W  = DSEL_W + 3;

  typedef struct packed {
    logic ctl_mark;
    logic data_err;
    logic wrong_cyl;
    logic bad_cyl;
    logic miss_mark;
  } res_flags_t;

endpackage

// File: rtl/drive_pin_sync.sv
module drive_pin_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/sector_flag_unit.sv
module sector_flag_unit
  import sector_status_pkg::*;
#(
  parameter int TRACK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_deleted,
  input  logic               mark_found,
  input  logic               mark_deleted,
  input  logic               crc_done,
  input  logic               crc_bad,
  input  logic               mark_timeout,
  input  logic               id_valid,
  input  logic [TRACK_W-1:0] id_track,
  input  logic [TRACK_W-1:0] cur_track,
  output res_flags_t         flags
);

  localparam logic [TRACK_W-1:0] BAD_TRACK = '1;

  logic cmd_del_q;
  logic track_diff;
  logic track_bad;
  logic mark_mismatch;

  assign track_diff    = (id_track != cur_track);
  assign track_bad     = track_diff && (id_track == BAD_TRACK);
  assign mark_mismatch = mark_deleted ^ cmd_del_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      cmd_del_q <= 1'b0;
    end else if (cmd_start) begin
      flags     <= '0;
      cmd_del_q <= cmd_deleted;
    end else begin
      flags.ctl_mark  <= flags.ctl_mark  | (mark_found & mark_mismatch);
      flags.data_err  <= flags.data_err  | (crc_done & crc_bad);
      flags.wrong_cyl <= flags.wrong_cyl | (id_valid & track_diff);
      flags.bad_cyl   <= flags.bad_cyl   | (id_valid & track_bad);
      flags.miss_mark <= flags.miss_mark | mark_timeout;
    end
  end

  // R7: command start clears every flag
  a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (flags == '0));

  // R2: mismatched mark sets the control-mark flag
  a_r2_ctl_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_found && !cmd_start && (mark_deleted != cmd_del_q)) |=> flags.ctl_mark);

  // R4: differing ID track sets wrong-cylinder
  a_r4_wrong_cyl: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !cmd_start && (id_track != cur_track)) |=> flags.wrong_cyl);

  // R5: bad-cylinder never appears without wrong-cylinder
  a_r5_bad_implies_wrong: assert property (@(posedge clk) disable iff (!rst_n)
    flags.bad_cyl |-> flags.wrong_cyl);

  // R7: a set flag holds while no command starts
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_start && (flags.data_err || flags.miss_mark)) |=>
      ($past(flags.data_err) -> flags.data_err) && ($past(flags.miss_mark) -> flags.miss_mark));

endmodule

// File: rtl/sector_status_gen.sv
module sector_status_gen
  import sector_status_pkg::*;
#(
  parameter int TRACK_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_deleted,
  input  logic               mark_found,
  input  logic               mark_deleted,
  input  logic               crc_done,
  input  logic               crc_bad,
  input  logic               mark_timeout,
  input  logic               id_valid,
  input  logic [TRACK_W-1:0] id_track,
  input  logic [TRACK_W-1:0] cur_track,
  input  logic               pin_wp,
  input  logic               pin_trk0,
  input  logic               pin_head,
  input  logic [DSEL_W-1:0]  pin_dsel,
  input  logic               force_wp,
  output logic [7:0]         result_byte,
  output logic [7:0]         drive_byte
);

  res_flags_t         flags;
  logic [PIN_W-1:0]   pins_raw;
  logic [PIN_W-1:0]   pins_sync;
  logic               wp_s;
  logic               trk0_s;
  logic               head_s;
  logic [DSEL_W-1:0]  dsel_s;

  sector_flag_unit #(
    .TRACK_W(TRACK_W)
  ) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .cmd_deleted  (cmd_deleted),
    .mark_found   (mark_found),
    .mark_deleted (mark_deleted),
    .crc_done     (crc_done),
    .crc_bad      (crc_bad),
    .mark_timeout (mark_timeout),
    .id_valid     (id_valid),
    .id_track     (id_track),
    .cur_track    (cur_track),
    .flags        (flags)
  );

  assign pins_raw = {pin_wp, pin_trk0, pin_head, pin_dsel};

  drive_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_raw),
    .dout  (pins_sync)
  );

  assign {wp_s, trk0_s, head_s, dsel_s} = pins_sync;

  assign result_byte = {1'b0, flags.ctl_mark, flags.data_err, flags.wrong_cyl,
                        2'b00, flags.bad_cyl, flags.miss_mark};

  assign drive_byte  = {1'b0, wp_s | force_wp, 1'b1, trk0_s,
                        1'b1, head_s, dsel_s};

  // R10: forced write protect always shows
  a_r10_force_wp: assert property (@(posedge clk) disable iff (!rst_n)
    force_wp |-> drive_byte[6]);

endmodule

// File: tb/sector_status_gen_bench.sv
`timescale 1ns/1ps
module sector_status_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 0, cmd_deleted = 0, mark_found = 0, mark_deleted = 0;
  logic       crc_done = 0, crc_bad = 0, mark_timeout = 0, id_valid = 0;
  logic [7:0] id_track = 0, cur_track = 0;
  logic       pin_wp = 0, pin_trk0 = 0, pin_head = 0, force_wp = 0;
  logic [1:0] pin_dsel = 0;
  logic [7:0] result_byte, drive_byte;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sector_status_gen u_sector_status_gen (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_deleted(cmd_deleted),
    .mark_found(mark_found), .mark_deleted(mark_deleted), .crc_done(crc_done),
    .crc_bad(crc_bad), .mark_timeout(mark_timeout), .id_valid(id_valid),
    .id_track(id_track), .cur_track(cur_track), .pin_wp(pin_wp), .pin_trk0(pin_trk0),
    .pin_head(pin_head), .pin_dsel(pin_dsel), .force_wp(force_wp),
    .result_byte(result_byte), .drive_byte(drive_byte));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic start_cmd(input logic del);
    cmd_start = 1; cmd_deleted = del; step(); cmd_start = 0;
  endtask

  task automatic t_reset();
    chk("R1 result in reset", result_byte, 8'h00);
    rst_n = 1; step(); step();
    chk("R1 result after reset", result_byte, 8'h00);
    chk("R1 drive after reset", drive_byte, 8'h28);
  endtask

  task automatic t_control_mark();
    start_cmd(0); mark_found = 1; mark_deleted = 1; step(); mark_found = 0;
    chk("R2 normal read, deleted mark", result_byte, 8'h40);
    start_cmd(0); mark_found = 1; mark_deleted = 0; step(); mark_found = 0;
    chk("R2 normal read, normal mark", result_byte, 8'h00);
    start_cmd(1); mark_found = 1; mark_deleted = 1; step(); mark_found = 0;
    chk("R2 deleted read, deleted mark", result_byte, 8'h00);
    mark_found = 1; mark_deleted = 0; step(); mark_found = 0;
    chk("R2 deleted read, normal mark", result_byte, 8'h40);
  endtask

  task automatic t_crc();
    start_cmd(0); crc_done = 1; crc_bad = 0; step(); crc_done = 0;
    chk("R3 crc good no effect", result_byte, 8'h00);
    crc_done = 1; crc_bad = 1; step(); crc_done = 0; crc_bad = 0;
    chk("R3 crc bad", result_byte, 8'h20);
  endtask

  task automatic t_track();
    start_cmd(0); id_track = 8'd7; cur_track = 8'd5; id_valid = 1; step(); id_valid = 0;
    chk("R4 differing track", result_byte, 8'h10);
    start_cmd(0); id_track = 8'd9; cur_track = 8'd9; id_valid = 1; step(); id_valid = 0;
    chk("R4 equal track", result_byte, 8'h00);
    start_cmd(0); id_track = 8'hFF; cur_track = 8'd3; id_valid = 1; step(); id_valid = 0;
    chk("R5 bad track", result_byte, 8'h12);
    start_cmd(0); id_track = 8'hFF; cur_track = 8'hFF; id_valid = 1; step(); id_valid = 0;
    chk("R5 FF equal", result_byte, 8'h00);
  endtask

  task automatic t_missing();
    start_cmd(0); mark_timeout = 1; step(); mark_timeout = 0;
    chk("R6 missing mark", result_byte, 8'h01);
  endtask

  task automatic t_sticky();
    start_cmd(0);
    crc_done = 1; crc_bad = 1; step(); crc_done = 0; crc_bad = 0;
    mark_timeout = 1; step(); mark_timeout = 0;
    chk("R7 accumulate", result_byte, 8'h21);
    step(); step(); step();
    chk("R7 held", result_byte, 8'h21);
    cmd_start = 1; mark_timeout = 1; id_valid = 1; id_track = 8'hFF; cur_track = 8'd0;
    step(); cmd_start = 0; mark_timeout = 0; id_valid = 0;
    chk("R7 start clears, events same cycle ignored", result_byte, 8'h00);
  endtask

  task automatic t_drive_pins();
    pin_wp = 1; pin_trk0 = 0; pin_head = 1; pin_dsel = 2'b10;
    step();
    chk("R9 not after one edge", drive_byte, 8'h28);
    step();
    chk("R8 R9 layout after two edges", drive_byte, 8'h6E);
    pin_wp = 0; pin_trk0 = 1; pin_head = 0; pin_dsel = 2'b01;
    step(); step();
    chk("R8 track0 and dsel", drive_byte, 8'h39);
    pin_trk0 = 0; pin_dsel = 2'b00; step(); step();
  endtask

  task automatic t_force_wp();
    force_wp = 1; #1;
    chk("R10 force immediate", drive_byte, 8'h68);
    step();
    chk("R10 force held, pin low", drive_byte, 8'h68);
    force_wp = 0; #1;
    chk("R10 force released", drive_byte, 8'h28);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_control_mark();
    t_crc();
    t_track();
    t_missing();
    t_sticky();
    t_drive_pins();
    t_force_wp();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule